// File: doc/BRIEF.md
# Motor Driver Fault Supervisor

This block watches the fault indicators of a dual H-bridge motor driver and decides which bridges may conduct. Each bridge has an overcurrent comparator flag and a gate-drive fault flag. The chip also has an overtemperature flag and a supply undervoltage flag. From these inputs the block builds a six-bit status word. It drives one enable per bridge, a gated copy of the step input, and an active-low fault output. That output is meant for an open-drain pad: a 0 pulls the pin low and a 1 releases it.

Overcurrent and gate-drive faults are sticky, and firmware must clear them. Overtemperature and undervoltage faults follow their flags and recover by themselves. Each overcurrent flag passes through a small qualifier state machine with three states: `QS_IDLE`, `QS_COUNT` and `QS_TRIP`. The machine makes these transitions:

- `QS_IDLE` to `QS_COUNT` on the first high sample.
- `QS_COUNT` to `QS_IDLE` when the flag drops early.
- `QS_COUNT` to `QS_TRIP` once the count has reached the programmed time while the flag is still high.
- `QS_TRIP` to `QS_IDLE` when the flag drops.

In `QS_TRIP` the machine asserts its trip output on every cycle while the flag stays high. The operating mode sets how far a bridge fault reaches. In direct PWM mode it shuts down only the bridge that faulted. In indexer mode it shuts down both bridges.

Top module: `motor_fault_supervisor`

## Requirements
- R1: After reset, status is 0, fault_n is 1, both bridge_en bits are 1, and step_out equals step_in.
- R2: Status bit i (i = 0 or 1) is the overcurrent bit of bridge i. It becomes 1 after oc_flag[i] has been sampled high on T+1 consecutive clock edges, and not before. T is selected by dly_sel: 0 gives 2, 1 gives 4, 2 gives 8 and 3 gives 16 cycles.
- R3: A low sample of oc_flag[i] before the bit has been set restarts the qualification count from zero.
- R4: Status bit 2+i is the gate-drive bit of bridge i. It is set on the first clock edge at which gd_flag[i] is high, with no qualification delay.
- R5: When idx_mode is 0, an overcurrent or gate-drive bit of bridge i clears only bridge_en[i].
- R6: When idx_mode is 1, any overcurrent or gate-drive bit clears both bridge_en bits.
- R7: Status bits 3:0 are sticky. A cycle with clr_en=1 clears each bit whose clr_mask bit is 0 and leaves each bit whose clr_mask bit is 1 unchanged.
- R8: A sticky bit whose fault is still present at the clear cycle stays 1.
- R9: Status bit 4 shows ot_flag one cycle late. While it is 1, both bridges are off. It returns to 0 by itself.
- R10: Status bit 5 shows uv_flag one cycle late. While it is 1, both bridges are off. It returns to 0 by itself.
- R11: fault_n is 0 exactly when some status bit is 1.
- R12: step_out is 0 while some status bit is 1, and equals step_in otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_mode | input | 1 | 0 selects direct PWM, 1 selects indexer |
| dly_sel | input | 2 | Overcurrent qualification time select |
| oc_flag | input | 2 | Overcurrent comparator flag for each bridge |
| gd_flag | input | 2 | Gate-drive fault flag for each bridge |
| ot_flag | input | 1 | Overtemperature flag |
| uv_flag | input | 1 | Undervoltage flag |
| step_in | input | 1 | Step request |
| clr_en | input | 1 | Status clear strobe |
| clr_mask | input | 4 | Per-bit clear mask for the sticky bits; a 0 bit clears |
| bridge_en | output | 2 | Enable for each bridge |
| step_out | output | 1 | Gated step |
| status | output | 6 | Status word |
| fault_n | output | 1 | Active-low fault; 0 means pull the pin low |

## Verification
The gate-drive, overtemperature and undervoltage bits all have one register of latency, so their effect is due one clock edge after the input changes. A clear takes effect at the edge that samples clr_en. An overcurrent bit is due at the (T+1)-th consecutive high edge. The bench therefore checks it as still 0 after T edges and as 1 after one more edge. bridge_en, step_out and fault_n are combinational from the status word and settle in the same cycle as the status bit they depend on. The bench drives inputs on falling edges and samples on the next falling edge, so every check sits half a period after the edge that produced it.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
    typedef enum logic [1:0] {
        QS_IDLE  = 2'd0,
        QS_COUNT = 2'd1,
        QS_TRIP  = 2'd2
    } qual_state_t;
endpackage

// File: rtl/mfs_oc_qual.sv
module mfs_oc_qual
    import mfs_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic [CNT_W-1:0] limit,
    output logic             trip
);
    qual_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= QS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        trip    = 1'b0;
        unique case (state_q)
            QS_IDLE: begin
                if (raw) begin
                    state_d = QS_COUNT;
                    cnt_d   = CNT_W'(1);
                end
            end
            QS_COUNT: begin
                if (!raw) begin
                    state_d = QS_IDLE;
                end else if (cnt_q >= limit) begin
                    state_d = QS_TRIP;
                    trip    = 1'b1;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            QS_TRIP: begin
                if (raw) trip = 1'b1;
                else     state_d = QS_IDLE;
            end
            default: state_d = QS_IDLE;
        endcase
    end

    // R2
    trip_needs_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> $past(raw));

    // R3
    count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == QS_COUNT) |-> (cnt_q != '0));
endmodule

// File: rtl/mfs_status_reg.sv
module mfs_status_reg #(
    parameter int N_STICKY = 4,
    parameter int N_LEVEL  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_STICKY+N_LEVEL-1:0]   set,
    input  logic                          clr_en,
    input  logic [N_STICKY-1:0]           clr_mask,
    output logic [N_STICKY+N_LEVEL-1:0]   q
);
    localparam int W = N_STICKY + N_LEVEL;

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (b < N_STICKY) begin : g_sticky
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q[b] <= 1'b0;
                else        q[b] <= (q[b] & ~(clr_en & ~clr_mask[b])) | set[b];
            end

            // R7
            sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (q[b] && !clr_en) |=> q[b]);

            // R8
            present_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set[b] |=> q[b]);
        end else begin : g_level
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q[b] <= 1'b0;
                else        q[b] <= set[b];
            end
        end
    end
endmodule

// File: rtl/motor_fault_supervisor.sv
module motor_fault_supervisor #(
    parameter int NB     = 2,
    parameter int DLY_T0 = 2,
    parameter int DLY_T1 = 4,
    parameter int DLY_T2 = 8,
    parameter int DLY_T3 = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            idx_mode,
    input  logic [1:0]      dly_sel,
    input  logic [NB-1:0]   oc_flag,
    input  logic [NB-1:0]   gd_flag,
    input  logic            ot_flag,
    input  logic            uv_flag,
    input  logic            step_in,
    input  logic            clr_en,
    input  logic [2*NB-1:0] clr_mask,
    output logic [NB-1:0]   bridge_en,
    output logic            step_out,
    output logic [2*NB+1:0] status,
    output logic            fault_n
);
    localparam int N_STICKY = 2 * NB;
    localparam int SW       = N_STICKY + 2;
    localparam int OC_LO    = 0;
    localparam int GD_LO    = NB;
    localparam int OT_BIT   = N_STICKY;
    localparam int UV_BIT   = N_STICKY + 1;
    localparam int M01      = (DLY_T0 > DLY_T1) ? DLY_T0 : DLY_T1;
    localparam int M23      = (DLY_T2 > DLY_T3) ? DLY_T2 : DLY_T3;
    localparam int DLY_MAX  = (M01 > M23) ? M01 : M23;
    localparam int CNT_W    = $clog2(DLY_MAX + 1);

    logic [CNT_W-1:0] limit;
    logic [NB-1:0]    oc_trip;
    logic [SW-1:0]    set_vec;
    logic [NB-1:0]    br_bad;
    logic             global_off;

    always_comb begin
        unique case (dly_sel)
            2'd0: limit = CNT_W'(DLY_T0);
            2'd1: limit = CNT_W'(DLY_T1);
            2'd2: limit = CNT_W'(DLY_T2);
            default: limit = CNT_W'(DLY_T3);
        endcase
    end

    for (genvar i = 0; i < NB; i++) begin : g_br
        mfs_oc_qual #(.CNT_W(CNT_W)) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (oc_flag[i]),
            .limit (limit),
            .trip  (oc_trip[i])
        );
        assign br_bad[i] = status[OC_LO+i] | status[GD_LO+i];
        assign bridge_en[i] = !(global_off | br_bad[i] | (idx_mode & (|br_bad)));
    end

    assign set_vec = {uv_flag, ot_flag, gd_flag, oc_trip};

    mfs_status_reg #(.N_STICKY(N_STICKY), .N_LEVEL(2)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (set_vec),
        .clr_en   (clr_en),
        .clr_mask (clr_mask),
        .q        (status)
    );

    assign global_off = status[OT_BIT] | status[UV_BIT];
    assign fault_n    = ~(|status);
    assign step_out   = step_in & fault_n;

    // R12
    step_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> !step_out);

    // R9
    ot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag |=> (bridge_en == '0));

    // R10
    uv_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> status[UV_BIT]);

    // R11
    ot_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ot_flag) |=> !fault_n);

    // R6
    idx_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_mode && (|status[N_STICKY-1:0])) |-> (bridge_en == '0));

    // R5
    direct_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_mode && !global_off && !status[OC_LO+1] && !status[GD_LO+1]) |-> bridge_en[1]);
endmodule

// File: tb/tb_motor_fault_supervisor.sv
module tb_motor_fault_supervisor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idx_mode = 1'b0;
    logic [1:0] dly_sel = 2'd0;
    logic [1:0] oc_flag = 2'b00;
    logic [1:0] gd_flag = 2'b00;
    logic       ot_flag = 1'b0;
    logic       uv_flag = 1'b0;
    logic       step_in = 1'b1;
    logic       clr_en = 1'b0;
    logic [3:0] clr_mask = 4'hF;
    logic [1:0] bridge_en;
    logic       step_out;
    logic [5:0] status;
    logic       fault_n;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    motor_fault_supervisor dut (
        .clk(clk), .rst_n(rst_n), .idx_mode(idx_mode), .dly_sel(dly_sel),
        .oc_flag(oc_flag), .gd_flag(gd_flag), .ot_flag(ot_flag), .uv_flag(uv_flag),
        .step_in(step_in), .clr_en(clr_en), .clr_mask(clr_mask),
        .bridge_en(bridge_en), .step_out(step_out), .status(status), .fault_n(fault_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic clear(input logic [3:0] m);
        clr_en = 1'b1; clr_mask = m;
        tick(1);
        clr_en = 1'b0; clr_mask = 4'hF;
    endtask

    task automatic t_reset;
        chk("R1 status", status, 6'd0);
        chk("R1 fault_n", fault_n, 1);
        chk("R1 bridge_en", bridge_en, 2'b11);
        chk("R1 step_out", step_out, 1);
    endtask

    task automatic t_gd_direct;
        idx_mode = 1'b0;
        gd_flag = 2'b10; tick(1);
        chk("R4 gd bit3", status, 6'b001000);
        chk("R5 only bridge1 off", bridge_en, 2'b01);
        chk("R11 fault_n low", fault_n, 0);
        chk("R12 step blocked", step_out, 0);
        gd_flag = 2'b00; tick(3);
        chk("R7 sticky held", status, 6'b001000);
        clear(4'b1111); tick(1);
        chk("R7 mask ones keep", status, 6'b001000);
        clear(4'b0111);
        chk("R7 cleared", status, 6'd0);
        chk("R5 restored", bridge_en, 2'b11);
        chk("R12 step passes", step_out, 1);
    endtask

    task automatic t_gd_indexer;
        idx_mode = 1'b1;
        gd_flag = 2'b01; tick(1);
        chk("R6 both off", bridge_en, 2'b00);
        clear(4'b1011);
        chk("R8 still set", status, 6'b000100);
        gd_flag = 2'b00; tick(1);
        clear(4'b1011);
        chk("R8 cleared after drop", status, 6'd0);
        idx_mode = 1'b0;
    endtask

    task automatic t_oc_delay(input logic [1:0] sel, input int t);
        dly_sel = sel;
        oc_flag = 2'b01; tick(t);
        chk("R2 not yet", status, 6'd0);
        tick(1);
        chk("R2 oc bit0 set", status, 6'b000001);
        chk("R5 oc bridge0 off", bridge_en, 2'b10);
        oc_flag = 2'b00; tick(1);
        clear(4'b1110);
        chk("R7 oc cleared", status, 6'd0);
    endtask

    task automatic t_oc_restart;
        dly_sel = 2'd0;
        oc_flag = 2'b10; tick(2);
        oc_flag = 2'b00; tick(1);
        oc_flag = 2'b10; tick(2);
        chk("R3 restart", status, 6'd0);
        tick(1);
        chk("R3 set after full run", status, 6'b000010);
        clear(4'b1101);
        chk("R8 oc reasserts", status, 6'b000010);
        oc_flag = 2'b00; tick(1);
        clear(4'b1101);
        chk("R8 oc cleared", status, 6'd0);
    endtask

    task automatic t_ot;
        ot_flag = 1'b1; tick(1);
        chk("R9 ot bit", status, 6'b010000);
        chk("R9 all off", bridge_en, 2'b00);
        chk("R11 ot pin", fault_n, 0);
        ot_flag = 1'b0; tick(1);
        chk("R9 auto clear", status, 6'd0);
        chk("R11 released", fault_n, 1);
    endtask

    task automatic t_uv;
        uv_flag = 1'b1; tick(1);
        chk("R10 uv bit", status, 6'b100000);
        chk("R10 all off", bridge_en, 2'b00);
        chk("R12 uv step", step_out, 0);
        uv_flag = 1'b0; tick(1);
        chk("R10 auto clear", status, 6'd0);
        chk("R10 resumed", bridge_en, 2'b11);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_gd_direct();
        t_gd_indexer();
        t_oc_delay(2'd1, 4);
        t_oc_delay(2'd3, 16);
        t_oc_restart();
        t_ot();
        t_uv();
        step_in = 1'b0; tick(1);
        chk("R12 follows step_in", step_out, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule